// File: doc/BRIEF.md
# SPI Packet Command Responder

This block is an SPI slave that takes the place of a small board housekeeping controller. An SPI master, which always starts the exchange, sends fixed packets of three bytes. The first byte carries a command, the second a data byte, and the third is a filler byte. During those same three bytes the slave returns a status byte, a zero byte and then a response byte. The slave decodes each command, updates its own state and prepares the response as soon as the data byte has arrived.

The state behind the commands is a 128-byte memory that keeps its contents across soft resets, with an address pointer that steps forward on every access. There is also a baud divisor register for a serial port, a fixed version code, a three-bit jumper value, and a one-cycle soft reset request. Status always describes the packet before, so the status seen in the first packet after reset carries no result. If the slave loses track of which byte of a packet it is in, a run of three 0x0F bytes puts it back in step.

The SPI pins are brought into the system clock domain through synchronizers. SCLK must therefore be slow compared with the system clock: each SCLK half period must last at least six system clock cycles.

Top module: `spi_pkt_responder`

## Requirements
- R1: Each packet is three bytes long, counted in the order command, data, filler. The byte position moves on after each received byte and returns to the command position after the filler. MISO carries the status byte in the command position, 0x00 in the data position and the response in the filler position.
- R2: The slave works in SPI mode 0. MOSI is sampled on the rising SCLK edge, MSB first. MISO changes only after a falling SCLK edge, MSB first, and the MSB of each byte is on MISO before that byte's first rising edge.
- R3: The status byte returned in the command position gives the result of the last completed packet. Bit 7 is set once any packet has completed, bit 1 flags an address error and bit 0 flags an unknown command. After reset the status is 0x00.
- R4: Command 0x03 returns the version code, 0x00 by default, whatever the data byte holds.
- R5: Command 0x0A with data 0xC4 raises soft_rst_req for exactly one clock cycle. Command 0x0A with any other data raises no request. Both return 0x00.
- R6: Command 0x0B returns the jumper inputs in bits 2..0 of the response, with bits 7..3 at zero.
- R7: Three 0x0F bytes received in a row, at any byte position, make the next received byte the command byte of a new packet. An aligned 0x0F/0x0F/0x0F packet returns 0x00.
- R8: Command 0x04 loads the data byte into baud_div (serial rate = 1.152 MHz / (baud_div + 1)). baud_div resets to 0x09, and no other command changes it.
- R9: Command 0x05 with data below 0x80 sets the memory pointer. Data of 0x80 or above leaves the pointer unchanged and sets the address error bit in the next status.
- R10: Command 0x0C writes the data byte at the pointer, then advances the pointer, wrapping from 0x7F to 0x00.
- R11: Command 0x0D returns the byte at the pointer, then advances the pointer with the same wrap.
- R12: After reset the memory holds 0x00 everywhere except location 0x7F, which holds the default baud divisor 0x09, and the pointer is 0x00.
- R13: Raising slave-select in the middle of a packet clears the bit count but keeps the byte position. An unknown command returns 0x00 and sets bit 0 of the next status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| mode_jmp | input | 3 | Jumper inputs, expected to be static |
| baud_div | output | 8 | Baud divisor for the serial port |
| soft_rst_req | output | 1 | One-cycle soft reset request |

## Verification
The hardest situation to reach from the ports is a slave that has lost its byte framing, because a correct master never sends a partial packet. The stimulus creates it on purpose. It sends a single command byte, raises slave-select, then sends three 0x0F bytes in one frame, and checks that the next ordinary packet is answered correctly. Two further directed cases complete the picture: a frame cut off after four bits, which must leave the byte position unchanged, and pointer accesses that wrap past 0x7F. Random packets then cover all commands, including unknown codes and out-of-range addresses.

// File: rtl/spr_pkg.sv
// Package: shared types and constants for the SPI packet command responder.
// Assumes: command codes and byte-position encoding are fixed by the packet format.
package spr_pkg;

    typedef enum logic [1:0] {
        POS_CMD  = 2'd0,
        POS_DATA = 2'd1,
        POS_RSP  = 2'd2
    } frame_pos_t;

    localparam logic [7:0] OP_VERSION = 8'h03;
    localparam logic [7:0] OP_BAUD    = 8'h04;
    localparam logic [7:0] OP_ADDR    = 8'h05;
    localparam logic [7:0] OP_SOFTRST = 8'h0A;
    localparam logic [7:0] OP_MODE    = 8'h0B;
    localparam logic [7:0] OP_MEMWR   = 8'h0C;
    localparam logic [7:0] OP_MEMRD   = 8'h0D;
    localparam logic [7:0] OP_RESYNC  = 8'h0F;

    localparam logic [7:0] SOFTRST_KEY = 8'hC4;
    localparam logic [7:0] RESYNC_BYTE = 8'h0F;

    localparam int ST_UNKNOWN = 0;
    localparam int ST_ADDRERR = 1;
    localparam int ST_VALID   = 7;

endpackage

// File: rtl/spr_spi_shifter.sv
// Module: spr_spi_shifter
// Synchronizes the SPI pins to clk, receives MOSI bytes MSB first on rising
// SCLK and shifts MISO on falling SCLK (mode 0).
// Assumes: each SCLK half period lasts at least SYNC_STAGES + 4 clk cycles.
// While the bit count is zero, the outgoing byte is reloaded every cycle from tx_byte.
module spr_spi_shifter #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [SYNC_STAGES-1:0] sclk_sync;
    logic [SYNC_STAGES-1:0] cs_sync;
    logic [SYNC_STAGES-1:0] mosi_sync;
    logic                   sclk_prev;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      rx_shift;
    logic [BYTE_W-1:0]      tx_shift;

    logic sclk_now, cs_active, mosi_now, sclk_rise, sclk_fall;

    assign sclk_now  = sclk_sync[SYNC_STAGES-1];
    assign cs_active = !cs_sync[SYNC_STAGES-1];
    assign mosi_now  = mosi_sync[SYNC_STAGES-1];
    assign sclk_rise = sclk_now && !sclk_prev;
    assign sclk_fall = !sclk_now && sclk_prev;
    assign miso      = tx_shift[BYTE_W-1];

    // Purpose: bring the asynchronous SPI pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
            sclk_prev <= sclk_now;
        end
    end

    // Purpose: count bits, assemble received bytes and shift the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_shift <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_shift <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!cs_active) begin
                bit_cnt  <= '0;
                tx_shift <= tx_byte;
            end else if (sclk_rise) begin
                rx_shift <= {rx_shift[BYTE_W-2:0], mosi_now};
                bit_cnt  <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_shift[BYTE_W-2:0], mosi_now};
                end
            end else if (sclk_fall && bit_cnt != '0) begin
                tx_shift <= {tx_shift[BYTE_W-2:0], 1'b0};
            end else if (bit_cnt == '0) begin
                tx_shift <= tx_byte;
            end
        end
    end

endmodule

// File: rtl/spr_framer.sv
// Module: spr_framer
// Tracks the byte position inside the three-byte packet and detects the
// resync run of consecutive 0x0F bytes.
// Assumes: rx_valid is a one-cycle pulse per received byte; a run of
// RESYNC_RUN resync bytes is only sent to realign.
module spr_framer
    import spr_pkg::*;
#(
    parameter int RESYNC_RUN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output frame_pos_t pos,
    output logic       cmd_done,
    output logic       data_done,
    output logic       pkt_done,
    output logic       resync_hit
);
    localparam int RUN_W = $clog2(RESYNC_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RESYNC_RUN - 1);

    logic [RUN_W-1:0] run_cnt;
    logic             is_sync_byte;

    assign is_sync_byte = (rx_byte == RESYNC_BYTE);
    assign resync_hit   = rx_valid && is_sync_byte && (run_cnt == RUN_LAST);
    assign cmd_done     = rx_valid && (pos == POS_CMD);
    assign data_done    = rx_valid && (pos == POS_DATA);
    assign pkt_done     = rx_valid && (pos == POS_RSP);

    // Purpose: next byte position for an ordinary byte.
    function automatic frame_pos_t next_pos(input frame_pos_t p);
        unique case (p)
            POS_CMD:  next_pos = POS_DATA;
            POS_DATA: next_pos = POS_RSP;
            default:  next_pos = POS_CMD;
        endcase
    endfunction

    // Purpose: advance the byte position and count the resync run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= POS_CMD;
            run_cnt <= '0;
        end else if (rx_valid) begin
            if (resync_hit) begin
                pos     <= POS_CMD;
                run_cnt <= '0;
            end else begin
                pos     <= next_pos(pos);
                run_cnt <= is_sync_byte ? run_cnt + 1'b1 : '0;
            end
        end
    end

endmodule

// File: rtl/spr_cmd_engine.sv
// Module: spr_cmd_engine
// Decodes the command once the data byte arrives, executes it, prepares the
// response byte and publishes the status at the end of each packet.
// Assumes: cmd_done, data_done and pkt_done come from the framer in packet
// order; mode_jmp is static while a packet is in flight.
module spr_cmd_engine
    import spr_pkg::*;
#(
    parameter int         MEM_DEPTH    = 128,
    parameter logic [7:0] VERSION_CODE = 8'h00,
    parameter logic [7:0] DEFAULT_BAUD = 8'h09,
    parameter int         MODE_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              data_done,
    input  logic              pkt_done,
    input  logic [7:0]        rx_byte,
    input  logic [MODE_W-1:0] mode_jmp,
    output logic [7:0]        status_byte,
    output logic [7:0]        resp_byte,
    output logic [7:0]        baud_div,
    output logic              soft_rst_req
);
    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);

    logic [7:0]        mem [MEM_DEPTH];
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        cmd_q;
    logic              pend_unknown;
    logic              pend_addrerr;
    logic              addr_ok;

    assign addr_ok = (int'(rx_byte) < MEM_DEPTH);

    // Purpose: pointer step with wrap at the last location.
    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
        step_ptr = (p == LAST_ADDR) ? '0 : p + 1'b1;
    endfunction

    // Purpose: command execution, memory, pointer, baud register and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                mem[i] <= (i == MEM_DEPTH - 1) ? DEFAULT_BAUD : 8'h00;
            end
            ptr          <= '0;
            cmd_q        <= '0;
            resp_byte    <= '0;
            baud_div     <= DEFAULT_BAUD;
            soft_rst_req <= 1'b0;
            pend_unknown <= 1'b0;
            pend_addrerr <= 1'b0;
            status_byte  <= '0;
        end else begin
            soft_rst_req <= 1'b0;
            if (cmd_done) begin
                cmd_q <= rx_byte;
            end
            if (data_done) begin
                pend_unknown <= 1'b0;
                pend_addrerr <= 1'b0;
                resp_byte    <= 8'h00;
                unique case (cmd_q)
                    OP_VERSION: resp_byte <= VERSION_CODE;
                    OP_BAUD:    baud_div  <= rx_byte;
                    OP_ADDR: begin
                        if (addr_ok) ptr <= rx_byte[ADDR_W-1:0];
                        else         pend_addrerr <= 1'b1;
                    end
                    OP_SOFTRST: soft_rst_req <= (rx_byte == SOFTRST_KEY);
                    OP_MODE:    resp_byte <= 8'(mode_jmp);
                    OP_MEMWR: begin
                        mem[ptr] <= rx_byte;
                        ptr      <= step_ptr(ptr);
                    end
                    OP_MEMRD: begin
                        resp_byte <= mem[ptr];
                        ptr       <= step_ptr(ptr);
                    end
                    OP_RESYNC:  resp_byte <= 8'h00;
                    default:    pend_unknown <= 1'b1;
                endcase
            end
            if (pkt_done) begin
                status_byte              <= '0;
                status_byte[ST_VALID]    <= 1'b1;
                status_byte[ST_ADDRERR]  <= pend_addrerr;
                status_byte[ST_UNKNOWN]  <= pend_unknown;
            end
        end
    end

endmodule

// File: rtl/spi_pkt_responder.sv
// Module: spi_pkt_responder (top)
// SPI mode-0 slave answering fixed three-byte command packets: byte shifting,
// framing with resync, and command execution, joined by the outgoing byte select.
// Assumes: SCLK is slow compared with clk (half period of at least six clk cycles).
module spi_pkt_responder
    import spr_pkg::*;
#(
    parameter int         SYNC_STAGES  = 2,
    parameter int         MEM_DEPTH    = 128,
    parameter logic [7:0] VERSION_CODE = 8'h00,
    parameter logic [7:0] DEFAULT_BAUD = 8'h09,
    parameter int         MODE_W       = 3,
    parameter int         RESYNC_RUN   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [MODE_W-1:0] mode_jmp,
    output logic [7:0]        baud_div,
    output logic              soft_rst_req
);
    logic       byte_done;
    logic [7:0] rx_byte;
    logic [7:0] tx_byte;
    logic [7:0] status_byte;
    logic [7:0] resp_byte;
    frame_pos_t frame_pos;
    logic       cmd_done, data_done, pkt_done, resync_hit;

    spr_spi_shifter #(
        .SYNC_STAGES (SYNC_STAGES),
        .BYTE_W      (8)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .rx_valid (byte_done),
        .rx_byte  (rx_byte)
    );

    spr_framer #(
        .RESYNC_RUN (RESYNC_RUN)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (byte_done),
        .rx_byte    (rx_byte),
        .pos        (frame_pos),
        .cmd_done   (cmd_done),
        .data_done  (data_done),
        .pkt_done   (pkt_done),
        .resync_hit (resync_hit)
    );

    spr_cmd_engine #(
        .MEM_DEPTH    (MEM_DEPTH),
        .VERSION_CODE (VERSION_CODE),
        .DEFAULT_BAUD (DEFAULT_BAUD),
        .MODE_W       (MODE_W)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_done     (cmd_done),
        .data_done    (data_done),
        .pkt_done     (pkt_done),
        .rx_byte      (rx_byte),
        .mode_jmp     (mode_jmp),
        .status_byte  (status_byte),
        .resp_byte    (resp_byte),
        .baud_div     (baud_div),
        .soft_rst_req (soft_rst_req)
    );

    // Purpose: pick the byte to shift out for the current packet position.
    always_comb begin
        unique case (frame_pos)
            POS_CMD:  tx_byte = status_byte;
            POS_RSP:  tx_byte = resp_byte;
            default:  tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/spr_checker.sv
// Module: spr_checker
// Property checks on the responder, attached to the top by bind.
module spr_checker
    import spr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       byte_done,
    input logic [7:0] rx_byte,
    input logic [1:0] frame_pos,
    input logic       resync_hit,
    input logic [7:0] status_byte,
    input logic [7:0] baud_div,
    input logic       soft_rst_req
);
    AST_POS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pos != 2'd3); // R1

    AST_STATUS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_byte) |-> $past(byte_done && frame_pos == 2'(POS_RSP))); // R3

    AST_SOFTRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |=> !soft_rst_req); // R5

    AST_SOFTRST_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(byte_done && frame_pos == 2'(POS_DATA) && rx_byte == SOFTRST_KEY)); // R5

    AST_RESYNC_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        resync_hit |=> frame_pos == 2'(POS_CMD)); // R7

    AST_BAUD_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(baud_div) |-> $past(byte_done && frame_pos == 2'(POS_DATA))); // R8
endmodule

bind spi_pkt_responder spr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .frame_pos    (frame_pos),
    .resync_hit   (resync_hit),
    .status_byte  (status_byte),
    .baud_div     (baud_div),
    .soft_rst_req (soft_rst_req)
);

// File: tb/spi_pkt_responder_tb.sv
// Bench: directed corner cases plus seeded random packets, checked against a
// model of the requirements kept in bench tasks.
module spi_pkt_responder_tb;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [2:0] mode_jmp = 3'd0;
    logic [7:0] baud_div;
    logic       soft_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int soft_cnt = 0;
    int soft_exp = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [128];
    logic [6:0] m_ptr;
    logic [7:0] m_baud;
    logic [7:0] m_status;

    always #4 clk = ~clk;

    spi_pkt_responder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (sclk),
        .spi_cs_n     (cs_n),
        .spi_mosi     (mosi),
        .spi_miso     (miso),
        .mode_jmp     (mode_jmp),
        .baud_div     (baud_div),
        .soft_rst_req (soft_rst_req)
    );

    // Count soft reset pulses away from the active edge.
    always @(negedge clk) if (rst_n && soft_rst_req) soft_cnt++;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic string op_tag(input logic [7:0] op);
        case (op)
            8'h03: op_tag = "R4 version";
            8'h04: op_tag = "R8 baud";
            8'h05: op_tag = "R9 address";
            8'h0A: op_tag = "R5 soft reset";
            8'h0B: op_tag = "R6 mode";
            8'h0C: op_tag = "R10 write";
            8'h0D: op_tag = "R11 read";
            8'h0F: op_tag = "R7 resync";
            default: op_tag = "R13 unknown";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m_mem[i] = (i == 127) ? 8'h09 : 8'h00;
        m_ptr = '0;
        m_baud = 8'h09;
        m_status = 8'h00;
    endtask

    // Expected effect of one complete packet.
    task automatic model_step(input logic [7:0] op, input logic [7:0] d, output logic [7:0] rsp);
        logic uk = 1'b0;
        logic ae = 1'b0;
        rsp = 8'h00;
        case (op)
            8'h03: rsp = 8'h00;
            8'h04: m_baud = d;
            8'h05: if (d < 8'h80) m_ptr = d[6:0]; else ae = 1'b1;
            8'h0A: if (d == 8'hC4) soft_exp++;
            8'h0B: rsp = {5'b0, mode_jmp};
            8'h0C: begin m_mem[m_ptr] = d; m_ptr = m_ptr + 1'b1; end
            8'h0D: begin rsp = m_mem[m_ptr]; m_ptr = m_ptr + 1'b1; end
            8'h0F: rsp = 8'h00;
            default: uk = 1'b1;
        endcase
        m_status = {1'b1, 5'b0, ae, uk};
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame3(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                          output logic [7:0] r1, output logic [7:0] r2, output logic [7:0] r3);
        cs_n = 1'b0;
        xfer(b1, r1);
        xfer(b2, r2);
        xfer(b3, r3);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // One packet with full checking against the model.
    task automatic pkt(input logic [7:0] op, input logic [7:0] d);
        logic [7:0] r1, r2, r3, rsp;
        frame3(op, d, 8'h00, r1, r2, r3);
        check(r1, m_status, "R3 status");
        check(r2, 8'h00, "R1 data-position byte");
        model_step(op, d, rsp);
        check(r3, rsp, op_tag(op));
        check(baud_div, m_baud, "R8 baud_div port");
        check(8'(soft_cnt), 8'(soft_exp), "R5 pulse count");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [7:0] r1, r2, r3, rsp, op;
        logic [7:0] ops [10] = '{8'h03, 8'h04, 8'h05, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0F, 8'h77, 8'h00};
        void'($urandom(32'h1234_5EED));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Reset state: R8, R5, R2 idle MISO carries status MSB (0)
        check(baud_div, 8'h09, "R8 reset baud_div");
        check(8'(soft_rst_req), 8'h00, "R5 reset request low");
        check(8'(miso), 8'h00, "R2 idle MISO");

        // First packet: status invalid 0x00 (R3), version (R4)
        pkt(8'h03, 8'h55);
        // R12: default memory contents, R11 read with wrap
        pkt(8'h05, 8'h7F);
        pkt(8'h0D, 8'h00);
        pkt(8'h0D, 8'h00);
        // R9: out-of-range address ignored, error reported
        pkt(8'h05, 8'h80);
        pkt(8'h0D, 8'h00);
        // R10: writes wrapping past the last location
        pkt(8'h05, 8'h7E);
        pkt(8'h0C, 8'hA5);
        pkt(8'h0C, 8'h5A);
        pkt(8'h0C, 8'h33);
        pkt(8'h05, 8'h7E);
        pkt(8'h0D, 8'h00);
        pkt(8'h0D, 8'h00);
        pkt(8'h0D, 8'h00);
        // R8: divisor table
        pkt(8'h04, 8'h04);
        pkt(8'h04, 8'h1F);
        pkt(8'h04, 8'h3D);
        pkt(8'h04, 8'h79);
        // R5: wrong key, then right key
        pkt(8'h0A, 8'h12);
        pkt(8'h0A, 8'hC5);
        pkt(8'h0A, 8'hC4);
        // R6: jumpers
        for (int j = 0; j < 8; j += 3) begin
            mode_jmp = 3'(j);
            pkt(8'h0B, 8'hFF);
        end
        // R13: unknown command
        pkt(8'h77, 8'h00);
        pkt(8'h03, 8'h00);
        // R7: aligned resync packet
        begin
            frame3(8'h0F, 8'h0F, 8'h0F, r1, r2, r3);
            check(r1, m_status, "R7 status before resync");
            model_step(8'h0F, 8'h0F, rsp);
            check(r3, 8'h00, "R7 aligned resync response");
        end
        pkt(8'h0B, 8'h00);

        // R13: frame cut after four bits keeps the byte position
        cs_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        pkt(8'h03, 8'h00);

        // R7 + R13: lose framing after one byte, then realign
        cs_n = 1'b0;
        xfer(8'h03, r1);
        check(r1, m_status, "R13 status in cut packet");
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        frame3(8'h0F, 8'h0F, 8'h0F, r1, r2, r3);
        check(r2, VERSION_RSP(), "R7 misaligned slave answers stale version");
        model_step(8'h03, 8'h0F, rsp);
        pkt(8'h03, 8'h00);
        pkt(8'h0B, 8'h00);

        // Random packets
        for (int n = 0; n < 200; n++) begin
            op = ops[$urandom_range(0, 9)];
            mode_jmp = 3'($urandom_range(0, 7));
            pkt(op, ($urandom_range(0, 15) == 0) ? 8'hC4 : 8'($urandom_range(0, 255)));
        end

        done = 1'b1;
        report();
    end

    function automatic logic [7:0] VERSION_RSP();
        VERSION_RSP = 8'h00;
    endfunction

endmodule